// File: doc/BRIEF.md
# Swallow-Counter Frequency Synthesizer Core

This block is the digital heart of a tuner frequency synthesizer. It receives two clock-enable strobes in a single system clock domain. The first marks each cycle of the crystal reference. The second marks each output cycle of an external dual-modulus prescaler on the local-oscillator path. The reference strobes go through a fixed divider to form the comparison pulse. With the default divide of 512, a 4 MHz crystal gives a 7.8125 kHz comparison rate.

The oscillator path is divided by a 14-bit programmable ratio. The ratio is split into a 9-bit main count M and a 5-bit swallow count S. The block drives the prescaler's modulus-select line high for the first S prescaler cycles of every divider period. The overall loop division is therefore 32·M + S.

A phase-frequency detector compares the two divided pulse trains and emits up/down pulses. A lock detector watches how long those pulses last in each comparison period. The ratio and four general control bits arrive as an 18-bit word on a clock/data serial port and take effect when a latch strobe rises. A new ratio enters the counters only at the next divider terminal count.

Top module: `fsyn_core`

## Requirements
- R1: `ref_out` is a one-cycle pulse emitted once for every REF_DIV `ref_tick` strobes. It is raised in the cycle after the REF_DIV-th strobe and never lasts two cycles.
- R2: `div_out` pulses once for every M `pre_tick` strobes, in the cycle after the terminal strobe. A main value of 0 behaves as 1.
- R3: In each divider period, `mod_hi` is high when the first min(S, M) `pre_tick` strobes arrive and low for the rest. It changes only in the cycle after a `pre_tick`.
- R4: The serial word is shifted in MSB first, one bit per rising edge of `ser_clk`, sampling `ser_dat`. After 18 bits, bits [17:14] hold the control nibble, bits [13:5] hold M and bits [4:0] hold S. A rising `ser_stb` captures the word, and the control nibble appears on `ctl_bits`.
- R5: A captured ratio does not alter the divider period in progress. It is applied at the next divider terminal count, and every later period uses it.
- R6: `pd_up` rises after a reference pulse and `pd_dn` rises after a divider pulse. When both would be set, both are cleared, so the two outputs are never high together.
- R7: `locked` rises at a reference pulse after LOCK_CNT consecutive comparison periods in each of which `pd_up`/`pd_dn` was high for fewer than LOCK_TOL cycles. A period at or above the limit drops it.
- R8: A latch strobe clears `locked` and the count of good periods at once. Lock then has to be earned again over LOCK_CNT periods.
- R9: After reset, `ref_out`, `div_out`, `pd_up`, `pd_dn` and `locked` are low. `ctl_bits` is zero, and `mod_hi` is low when DEF_SWAL is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe per crystal reference cycle |
| pre_tick | input | 1 | One-cycle strobe per prescaler output cycle |
| ser_clk | input | 1 | Serial port clock, sampled by clk |
| ser_dat | input | 1 | Serial port data |
| ser_stb | input | 1 | Latch strobe, rising edge captures the word |
| ref_out | output | 1 | Divided reference pulse |
| div_out | output | 1 | Divided oscillator pulse |
| mod_hi | output | 1 | Prescaler modulus select, high selects the larger modulus |
| pd_up | output | 1 | Phase detector up pulse |
| pd_dn | output | 1 | Phase detector down pulse |
| locked | output | 1 | Lock indication |
| ctl_bits | output | 4 | Control nibble from the last captured word |

## Verification
The bench builds the core with REF_DIV = 8, DEF_MAIN = 8, LOCK_TOL = 3 and LOCK_CNT = 8. Under these values the reference chain and the reset-time divider count in step, so a zero-error loop reaches lock within about 65 cycles. This also makes it possible to count exactly how many periods it takes to drop and regain lock. The small reference divide also lets the detector be driven into sustained up or down states within a few dozen cycles. The full 9-bit and 5-bit ratio fields are still exercised, including a main value of zero and swallow values equal to or larger than the main value.

// File: rtl/fsyn_pkg.sv
package fsyn_pkg;
    localparam int MAIN_W = 9;
    localparam int SWAL_W = 5;
    localparam int CTL_W  = 4;
    localparam int WORD_W = CTL_W + MAIN_W + SWAL_W;

    typedef struct packed {
        logic [CTL_W-1:0]  ctl;
        logic [MAIN_W-1:0] main;
        logic [SWAL_W-1:0] swal;
    } word_t;
endpackage

// File: rtl/fsyn_serial_port.sv
module fsyn_serial_port
    import fsyn_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ser_clk,
    input  logic  ser_dat,
    input  logic  ser_stb,
    output word_t word,
    output logic  load
);
    typedef struct packed {
        logic              sclk;
        logic              stb;
        logic [WORD_W-1:0] sr;
        logic [WORD_W-1:0] word;
        logic              load;
    } sp_t;

    sp_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sclk = ser_clk;
        st_d.stb  = ser_stb;
        st_d.load = 1'b0;
        if (ser_clk && !st_q.sclk)
            st_d.sr = {st_q.sr[WORD_W-2:0], ser_dat};
        if (ser_stb && !st_q.stb) begin
            st_d.word = st_q.sr;
            st_d.load = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word = word_t'(st_q.word);
    assign load = st_q.load;

    // R4
    load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);
endmodule

// File: rtl/fsyn_ref_divider.sv
module fsyn_ref_divider #(
    parameter int REF_DIV = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    output logic ref_out
);
    generate
        if (REF_DIV < 2) begin : g_bypass
            logic pulse_d, pulse_q;
            always_comb pulse_d = ref_tick;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pulse_q <= 1'b0;
                else        pulse_q <= pulse_d;
            end
            assign ref_out = pulse_q;
        end else begin : g_count
            localparam int CW = $clog2(REF_DIV);
            localparam logic [CW-1:0] LAST = CW'(REF_DIV - 1);

            typedef struct packed {
                logic [CW-1:0] cnt;
                logic          pulse;
            } rd_t;

            rd_t st_d, st_q;

            always_comb begin
                st_d       = st_q;
                st_d.pulse = 1'b0;
                if (ref_tick) begin
                    if (st_q.cnt == LAST) begin
                        st_d.cnt   = '0;
                        st_d.pulse = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign ref_out = st_q.pulse;

            // R1
            ref_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ref_out |=> !ref_out);
        end
    endgenerate
endmodule

// File: rtl/fsyn_swallow_divider.sv
module fsyn_swallow_divider
    import fsyn_pkg::*;
#(
    parameter int DEF_MAIN = 8,
    parameter int DEF_SWAL = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_tick,
    input  logic              ld,
    input  logic [MAIN_W-1:0] new_main,
    input  logic [SWAL_W-1:0] new_swal,
    output logic              div_out,
    output logic              mod_hi
);
    localparam logic [MAIN_W-1:0] RST_MAIN = MAIN_W'(DEF_MAIN);
    localparam logic [SWAL_W-1:0] RST_SWAL = SWAL_W'(DEF_SWAL);

    typedef struct packed {
        logic [MAIN_W-1:0] main;
        logic [SWAL_W-1:0] swal;
        logic [MAIN_W-1:0] act_main;
        logic [SWAL_W-1:0] act_swal;
        logic [MAIN_W-1:0] pend_main;
        logic [SWAL_W-1:0] pend_swal;
        logic              pend;
        logic              div;
    } dv_t;

    dv_t  st_d, st_q;
    logic terminal;

    always_comb terminal = (st_q.main < MAIN_W'(2));

    always_comb begin
        st_d     = st_q;
        st_d.div = 1'b0;
        if (ld) begin
            st_d.pend      = 1'b1;
            st_d.pend_main = new_main;
            st_d.pend_swal = new_swal;
        end
        if (pre_tick) begin
            if (terminal) begin
                st_d.div = 1'b1;
                if (st_q.pend) begin
                    st_d.main     = st_q.pend_main;
                    st_d.swal     = st_q.pend_swal;
                    st_d.act_main = st_q.pend_main;
                    st_d.act_swal = st_q.pend_swal;
                    st_d.pend     = ld;
                end else begin
                    st_d.main = st_q.act_main;
                    st_d.swal = st_q.act_swal;
                end
            end else begin
                st_d.main = st_q.main - 1'b1;
                if (st_q.swal != '0)
                    st_d.swal = st_q.swal - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.main     <= RST_MAIN;
            st_q.swal     <= RST_SWAL;
            st_q.act_main <= RST_MAIN;
            st_q.act_swal <= RST_SWAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_out = st_q.div;
    assign mod_hi  = (st_q.swal != '0);

    // R3
    mod_change_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mod_hi) |-> $past(pre_tick));

    // R2
    div_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_out |-> $past(pre_tick));
endmodule

// File: rtl/fsyn_phase_lock.sv
module fsyn_phase_lock #(
    parameter int LOCK_TOL = 16,
    parameter int LOCK_CNT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_p,
    input  logic div_p,
    input  logic clr,
    output logic pd_up,
    output logic pd_dn,
    output logic locked
);
    localparam int ERR_W  = $clog2(LOCK_TOL + 1);
    localparam int GOOD_W = $clog2(LOCK_CNT + 1);
    localparam logic [ERR_W-1:0]  TOL_V  = ERR_W'(LOCK_TOL);
    localparam logic [GOOD_W-1:0] GOOD_M = GOOD_W'(LOCK_CNT);
    localparam logic [GOOD_W-1:0] GOOD_L = GOOD_W'(LOCK_CNT - 1);

    typedef struct packed {
        logic              up;
        logic              dn;
        logic [ERR_W-1:0]  err;
        logic [GOOD_W-1:0] good;
        logic              locked;
    } pl_t;

    pl_t  st_d, st_q;
    logic up_set, dn_set;

    always_comb begin
        up_set = st_q.up | ref_p;
        dn_set = st_q.dn | div_p;
        st_d   = st_q;
        if (up_set && dn_set) begin
            st_d.up = 1'b0;
            st_d.dn = 1'b0;
        end else begin
            st_d.up = up_set;
            st_d.dn = dn_set;
        end

        if (clr) begin
            st_d.err    = '0;
            st_d.good   = '0;
            st_d.locked = 1'b0;
        end else if (ref_p) begin
            if (st_q.err < TOL_V) begin
                if (st_q.good != GOOD_M)
                    st_d.good = st_q.good + 1'b1;
                if (st_q.good >= GOOD_L)
                    st_d.locked = 1'b1;
            end else begin
                st_d.good   = '0;
                st_d.locked = 1'b0;
            end
            st_d.err = '0;
        end else if ((st_q.up || st_q.dn) && st_q.err != TOL_V) begin
            st_d.err = st_q.err + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pd_up  = st_q.up;
    assign pd_dn  = st_q.dn;
    assign locked = st_q.locked;

    // R6
    up_dn_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pd_up && pd_dn));

    // R7
    lock_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(ref_p));

    // R8
    lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !locked);
endmodule

// File: rtl/fsyn_core.sv
module fsyn_core
    import fsyn_pkg::*;
#(
    parameter int REF_DIV  = 512,
    parameter int DEF_MAIN = 8,
    parameter int DEF_SWAL = 0,
    parameter int LOCK_TOL = 16,
    parameter int LOCK_CNT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             pre_tick,
    input  logic             ser_clk,
    input  logic             ser_dat,
    input  logic             ser_stb,
    output logic             ref_out,
    output logic             div_out,
    output logic             mod_hi,
    output logic             pd_up,
    output logic             pd_dn,
    output logic             locked,
    output logic [CTL_W-1:0] ctl_bits
);
    word_t            word;
    logic             load;
    logic [CTL_W-1:0] ctl_d, ctl_q;

    fsyn_serial_port u_port (
        .clk    (clk),
        .rst_n  (rst_n),
        .ser_clk(ser_clk),
        .ser_dat(ser_dat),
        .ser_stb(ser_stb),
        .word   (word),
        .load   (load)
    );

    fsyn_ref_divider #(.REF_DIV(REF_DIV)) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_tick(ref_tick),
        .ref_out (ref_out)
    );

    fsyn_swallow_divider #(.DEF_MAIN(DEF_MAIN), .DEF_SWAL(DEF_SWAL)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .pre_tick(pre_tick),
        .ld      (load),
        .new_main(word.main),
        .new_swal(word.swal),
        .div_out (div_out),
        .mod_hi  (mod_hi)
    );

    fsyn_phase_lock #(.LOCK_TOL(LOCK_TOL), .LOCK_CNT(LOCK_CNT)) u_pl (
        .clk   (clk),
        .rst_n (rst_n),
        .ref_p (ref_out),
        .div_p (div_out),
        .clr   (load),
        .pd_up (pd_up),
        .pd_dn (pd_dn),
        .locked(locked)
    );

    always_comb ctl_d = load ? word.ctl : ctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ctl_bits = ctl_q;

    // R4
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) |-> $stable(ctl_bits));
endmodule

// File: tb/sim_fsyn_core.sv
module sim_fsyn_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0, pre_tick = 1'b0;
    logic       ser_clk = 1'b0, ser_dat = 1'b0, ser_stb = 1'b0;
    logic       ref_out, div_out, mod_hi, pd_up, pd_dn, locked;
    logic [3:0] ctl_bits;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    fsyn_core #(.REF_DIV(8), .DEF_MAIN(8), .DEF_SWAL(0), .LOCK_TOL(3), .LOCK_CNT(8)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .pre_tick(pre_tick),
        .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_stb(ser_stb),
        .ref_out(ref_out), .div_out(div_out), .mod_hi(mod_hi),
        .pd_up(pd_up), .pd_dn(pd_dn), .locked(locked), .ctl_bits(ctl_bits)
    );

    // {ctl[3:0], main[8:0], swallow[4:0]}
    localparam logic [17:0] VEC [0:7] = '{
        {4'hA, 9'd8,  5'd3},
        {4'h3, 9'd5,  5'd0},
        {4'h5, 9'd20, 5'd19},
        {4'hC, 9'd1,  5'd0},
        {4'h6, 9'd0,  5'd0},
        {4'h9, 9'd6,  5'd6},
        {4'hF, 9'd3,  5'd9},
        {4'h0, 9'd37, 5'd31}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic program_word(input logic [17:0] w);
        for (int i = 17; i >= 0; i--) begin
            ser_dat = w[i];
            wait_cyc(2);
            ser_clk = 1'b1;
            wait_cyc(2);
            ser_clk = 1'b0;
            wait_cyc(2);
        end
        ser_stb = 1'b1;
        wait_cyc(2);
        ser_stb = 1'b0;
        wait_cyc(2);
    endtask

    // one prescaler strobe; m = modulus select seen by it, d = divider pulse it caused
    task automatic tick1(output logic m, output logic d);
        @(negedge clk);
        pre_tick = 1'b1;
        m = mod_hi;
        @(negedge clk);
        pre_tick = 1'b0;
        d = div_out;
    endtask

    task automatic sync_period();
        logic m, d;
        d = 1'b0;
        for (int k = 0; k < 600 && !d; k++) tick1(m, d);
    endtask

    task automatic measure(output int n, output int h);
        logic m, d;
        n = 0; h = 0; d = 1'b0;
        for (int k = 0; k < 600 && !d; k++) begin
            tick1(m, d);
            n++;
            if (m) h++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cnt, n, h, n2, h2, pm, ph;
        logic m, d;

        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        // R9 reset state
        check("R9 ref_out", ref_out, 0);
        check("R9 div_out", div_out, 0);
        check("R9 mod_hi", mod_hi, 0);
        check("R9 pd_up", pd_up, 0);
        check("R9 pd_dn", pd_dn, 0);
        check("R9 locked", locked, 0);
        check("R9 ctl_bits", ctl_bits, 0);

        // R1 / R7: aligned reference and divider, zero phase error
        ref_tick = 1'b1;
        pre_tick = 1'b1;
        cnt = 0;
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            if (ref_out) cnt++;
        end
        check("R1 ref pulses in 64 strobes", cnt, 8);
        check("R7 no lock before 8 periods", locked, 0);
        wait_cyc(6);
        check("R7 lock after 8 good periods", locked, 1);

        // R8: latch strobe clears lock, then lock returns
        program_word({4'h0, 9'd8, 5'd0});
        check("R8 lock cleared by load", locked, 0);
        wait_cyc(80);
        check("R8 lock regained", locked, 1);

        // R6: reference only -> up, then divider only -> down
        pre_tick = 1'b0;
        wait_cyc(10);
        check("R6 up after reference", pd_up, 1);
        check("R6 no down", pd_dn, 0);
        wait_cyc(40);
        check("R7 lock dropped on long error", locked, 0);
        ref_tick = 1'b0;
        pre_tick = 1'b1;
        wait_cyc(20);
        check("R6 up cleared by divider", pd_up, 0);
        check("R6 down after divider", pd_dn, 1);
        pre_tick = 1'b0;

        rst_n = 1'b0;
        wait_cyc(2);
        rst_n = 1'b1;
        wait_cyc(2);

        // R2 R3 R4: vector table
        foreach (VEC[i]) begin
            pm = (VEC[i][13:5] == 9'd0) ? 1 : int'(VEC[i][13:5]);
            ph = (int'(VEC[i][4:0]) < pm) ? int'(VEC[i][4:0]) : pm;
            program_word(VEC[i]);
            check("R4 ctl_bits", ctl_bits, int'(VEC[i][17:14]));
            sync_period();
            measure(n, h);
            check("R2 divider period", n, pm);
            check("R3 high-modulus strobes", h, ph);
        end

        // R5: new ratio mid-period leaves current period intact
        program_word({4'h1, 9'd7, 5'd2});
        sync_period();
        measure(n, h);
        check("R5 setup period", n, 7);
        h2 = 0;
        for (int k = 0; k < 3; k++) begin
            tick1(m, d);
            if (m) h2++;
        end
        program_word({4'h2, 9'd4, 5'd1});
        measure(n2, h);
        check("R5 period in progress keeps old ratio", n2 + 3, 7);
        check("R5 old swallow in progress", h + h2, 2);
        measure(n, h);
        check("R5 next period uses new ratio", n, 4);
        check("R5 next swallow", h, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule